// File: doc/BRIEF.md
# Memory Fault Classification Unit

This block sits beside the load/store pipeline and decides what happens to every error reported against a memory access. Errors arrive from three places: the response path of the bus master, the error lines of the tightly-coupled memory port, and the parity/ECC checkers on the cache and tightly-coupled RAMs. For each error the unit works out the outcome. The access may be dropped, silently fixed, fixed and aborted, aborted, replayed, or answered with a slave error toward the bus slave port. For an abort it also works out whether the abort is precise or imprecise, and whether the fault is correctable and recoverable.

A classified error is parked in a small table indexed by the access ID. Nothing visible happens until that access commits. If the access is flushed first, the error is discarded. All commit results appear one cycle after the commit. Imprecise aborts first pass through a holding stage, so they come out one cycle later than precise aborts, and precise aborts always win the single abort output. Detection events fire one cycle after an error is seen, whatever the outcome.

The unit assumes at most one detection per access ID between its allocation and its commit or flush. It also assumes that a detection never arrives in the same cycle as a commit or flush of the same ID. If it does, the detection is discarded.

Top module: `memfault_classifier`

## Requirements
- R1: A bus error has source 0 and a response of 2 (slave error) or 3 (decode error). When the access commits, the error gives an abort. The abort is precise for access kinds 0 (fetch) and 1 (load), and for kind 2 (store) to memory type 2 (strongly ordered). It is imprecise for stores to type 0 (normal) or type 1 (device), and for kind 3 (maintenance). Responses 0 and 1 give no error.
- R2: A bus load with the exclusive flag set that gets response 0 (OKAY) is treated exactly like a slave error. An exclusive load with response 1 (exclusive OKAY) is not an error.
- R3: RAM errors have source 2. Their abort is precise for fetches and loads, and precise for stores when the in-TCM flag is 1. It is imprecise for stores when the in-TCM flag is 0, and imprecise for maintenance operations.
- R4: The policy input selects the handling of RAM errors. Value 0 ignores the error. Value 1 aborts without a fix. Value 2 fixes without an abort. Value 3 fixes and aborts. Under policy 2 or 3, an error that cannot be fixed is aborted and not fixed. A fix shows as fix_valid with fix_id one cycle after the commit.
- R5: While dbg_halt is 1, a fixable RAM error under policy 2 is both fixed and aborted.
- R6: evt_det pulses one cycle after any detected error, whether or not an abort follows. evt_det_corr also pulses when that error is a fixable RAM error, under any policy.
- R7: Abort, fix, replay and slave-error outputs pulse only as a result of a commit of an ID holding an error, with exactly one result per committed access. A flush of the ID before its commit discards the error. abt_valid is itself the abort event.
- R8: abt_corr and abt_recov are both 1 on an abort of a fixable RAM error, and both 0 on a bus error abort.
- R9: Tightly-coupled port errors have source 1. A read (any kind but 2) gives a precise abort, and a write (kind 2) gives an imprecise abort. When the from-slave flag is 1, the unit gives slverr_valid instead of any abort.
- R10: A tightly-coupled port read error with the retry flag set gives replay_valid and no abort. A write with retry set still gives an imprecise abort.
- R11: A precise abort appears on abt_* in the cycle after its commit. An imprecise abort appears two cycles after its commit. When a precise abort and a held imprecise abort compete, the precise one is issued and the imprecise one follows in the next cycle.
- R12: During and right after reset, all outputs are 0 and no error is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| det_valid | input | 1 | Error report valid this cycle |
| det_id | input | ID_W | Access ID of the report |
| det_src | input | 2 | 0 bus, 1 TCM port, 2 RAM check, 3 none |
| det_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 maintenance |
| det_mem | input | 2 | 0 normal, 1 device, 2 strongly ordered |
| det_resp | input | 2 | Bus response: 0 OKAY, 1 EXOKAY, 2 SLVERR, 3 DECERR |
| det_excl | input | 1 | Access was exclusive |
| det_in_tcm | input | 1 | RAM error is in TCM (1) or cache (0) |
| det_fixable | input | 1 | Hardware is able to correct the RAM error |
| det_retry | input | 1 | TCM port requested a retry |
| det_from_slave | input | 1 | TCM access came from the slave port |
| ecc_policy | input | 2 | RAM error policy (see R4) |
| dbg_halt | input | 1 | Core is in debug-halt state |
| cmt_valid | input | 1 | Access commits this cycle |
| cmt_id | input | ID_W | ID of committing access |
| fls_valid | input | 1 | Access is flushed this cycle |
| fls_id | input | ID_W | ID of flushed access |
| evt_det | output | 1 | Error detected event |
| evt_det_corr | output | 1 | Correctable error detected event |
| abt_valid | output | 1 | Abort taken |
| abt_precise | output | 1 | Abort is precise |
| abt_id | output | ID_W | ID of aborted access |
| abt_corr | output | 1 | Aborted fault is correctable |
| abt_recov | output | 1 | Aborted fault is recoverable |
| replay_valid | output | 1 | Replay request |
| replay_id | output | ID_W | ID to replay |
| slverr_valid | output | 1 | Return slave error to the slave port |
| slverr_id | output | ID_W | ID for the slave error |
| fix_valid | output | 1 | Apply correction |
| fix_id | output | ID_W | ID to correct |

## Verification
Bus errors are tried with every response code, with and without the exclusive flag, across all access kinds and memory types. This separates the precise and imprecise split from the no-error cases and from the exclusive-OKAY reclassification. RAM errors are swept over all four policies, fixable and unfixable, and with and without debug halt. These sweeps tell silent fixes from fix-plus-abort, and ignored errors from events that still fire. Port errors cover reads, writes, retry and slave-origin accesses, which shows replay and slave error displacing the abort. Flushes before commit, commits with no pending error, and back-to-back imprecise-then-precise commits show the drop, the one-result rule and the precise-first ordering.

// File: rtl/mfc_pkg.sv
// Shared encodings and the per-access fault descriptor for the fault classifier.
package mfc_pkg;
    typedef enum logic [1:0] {SRC_BUS = 2'd0, SRC_TCMP = 2'd1, SRC_RAM = 2'd2, SRC_NONE = 2'd3} src_e;
    typedef enum logic [1:0] {K_FETCH = 2'd0, K_LOAD = 2'd1, K_STORE = 2'd2, K_MAINT = 2'd3} kind_e;
    typedef enum logic [1:0] {M_NORMAL = 2'd0, M_DEVICE = 2'd1, M_STRONG = 2'd2, M_RSVD = 2'd3} mem_e;
    typedef enum logic [1:0] {R_OKAY = 2'd0, R_EXOKAY = 2'd1, R_SLVERR = 2'd2, R_DECERR = 2'd3} resp_e;
    typedef enum logic [1:0] {P_IGNORE = 2'd0, P_ABORT = 2'd1, P_FIX = 2'd2, P_FIX_ABORT = 2'd3} pol_e;

    // Outcome decided for one erroneous access
    typedef struct packed {
        logic abort;
        logic precise;
        logic slverr;
        logic replay;
        logic fix;
        logic corr;
        logic recov;
    } fault_t;
endpackage

// File: rtl/mfc_classify.sv
// Combinational classifier: turns one error report plus the current policy
// into an error flag and an outcome descriptor.
// Assumes the source field is valid whenever the report is valid.
module mfc_classify
    import mfc_pkg::*;
(
    input  logic [1:0] src,
    input  logic [1:0] kind,
    input  logic [1:0] mem,
    input  logic [1:0] resp,
    input  logic       excl,
    input  logic       in_tcm,
    input  logic       fixable,
    input  logic       retry,
    input  logic       from_slave,
    input  logic [1:0] policy,
    input  logic       halt,
    output logic       err,
    output fault_t     flt
);
    src_e  s;
    kind_e k;
    mem_e  m;
    resp_e r;
    pol_e  p;
    logic  is_read;

    assign s = src_e'(src);
    assign k = kind_e'(kind);
    assign m = mem_e'(mem);
    assign r = resp_e'(resp);
    assign p = pol_e'(policy);
    assign is_read = (k != K_STORE);

    // Per-source decision of error presence and outcome
    always_comb begin
        err = 1'b0;
        flt = '0;
        unique case (s)
            SRC_BUS: begin
                err = (r == R_SLVERR) || (r == R_DECERR) ||
                      (excl && (k == K_LOAD) && (r == R_OKAY));
                flt.abort   = err;
                flt.precise = (k == K_FETCH) || (k == K_LOAD) ||
                              ((k == K_STORE) && (m == M_STRONG));
            end
            SRC_TCMP: begin
                err = 1'b1;
                if (from_slave) begin
                    flt.slverr = 1'b1;
                end else if (is_read && retry) begin
                    flt.replay = 1'b1;
                    flt.recov  = 1'b1;
                end else begin
                    flt.abort   = 1'b1;
                    flt.precise = is_read;
                end
            end
            SRC_RAM: begin
                err = 1'b1;
                flt.corr  = fixable;
                flt.recov = fixable;
                unique case (p)
                    P_IGNORE:    ;
                    P_ABORT:     flt.abort = 1'b1;
                    P_FIX: begin
                        flt.fix   = fixable;
                        flt.abort = !fixable || halt;
                    end
                    P_FIX_ABORT: begin
                        flt.fix   = fixable;
                        flt.abort = 1'b1;
                    end
                    default: ;
                endcase
                if (k == K_MAINT)      flt.precise = 1'b0;
                else if (k == K_STORE) flt.precise = in_tcm;
                else                   flt.precise = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mfc_pend_table.sv
// Pending-error table, one entry per access ID. An entry is written on a
// classified error and cleared by commit or flush of its ID; a commit of a
// valid entry is reported combinationally as a hit with the stored outcome.
// Assumes a write is never needed in the cycle its ID commits or flushes.
module mfc_pend_table
    import mfc_pkg::*;
#(
    parameter int ID_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [ID_W-1:0] wr_id,
    input  fault_t          wr_flt,
    input  logic            cmt_valid,
    input  logic [ID_W-1:0] cmt_id,
    input  logic            fls_valid,
    input  logic [ID_W-1:0] fls_id,
    output logic            hit,
    output fault_t          hit_flt
);
    localparam int NID = 1 << ID_W;

    logic [NID-1:0] ent_v;
    fault_t         ent_f [NID];
    logic           wr_ok;

    assign wr_ok   = wr_en && !(cmt_valid && (cmt_id == wr_id)) &&
                     !(fls_valid && (fls_id == wr_id));
    assign hit     = cmt_valid && ent_v[cmt_id] && !(fls_valid && (fls_id == cmt_id));
    assign hit_flt = ent_f[cmt_id];

    for (genvar g = 0; g < NID; g++) begin : g_ent
        logic clr_g;
        logic set_g;
        assign clr_g = (cmt_valid && (cmt_id == ID_W'(g))) ||
                       (fls_valid && (fls_id == ID_W'(g)));
        assign set_g = wr_ok && (wr_id == ID_W'(g));

        // Entry state: clear on commit/flush, capture on new error
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_v[g] <= 1'b0;
                ent_f[g] <= '0;
            end else if (clr_g) begin
                ent_v[g] <= 1'b0;
            end else if (set_g) begin
                ent_v[g] <= 1'b1;
                ent_f[g] <= wr_flt;
            end
        end
    end

    // A flushed ID holds no error afterwards (R7)
    p_flush_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fls_valid |=> !ent_v[$past(fls_id)]);
endmodule

// File: rtl/mfc_abort_arb.sv
// Abort issue stage: precise aborts go straight to the output register;
// imprecise aborts are held in per-ID ready bits and issued, lowest ID first,
// in a cycle with no precise abort.
// Assumes an ID is not committed again while its imprecise abort is held.
module mfc_abort_arb #(
    parameter int ID_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            prec_in,
    input  logic [ID_W-1:0] prec_id,
    input  logic            prec_corr,
    input  logic            prec_recov,
    input  logic            imp_in,
    input  logic [ID_W-1:0] imp_id,
    input  logic            imp_corr,
    input  logic            imp_recov,
    output logic            abt_valid,
    output logic            abt_precise,
    output logic [ID_W-1:0] abt_id,
    output logic            abt_corr,
    output logic            abt_recov
);
    localparam int NID = 1 << ID_W;

    logic [NID-1:0] imp_rdy;
    logic [NID-1:0] imp_c;
    logic [NID-1:0] imp_r;
    logic           found;
    logic [ID_W-1:0] sel;

    // Lowest-numbered held imprecise abort
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = NID - 1; i >= 0; i--) begin
            if (imp_rdy[i]) begin
                found = 1'b1;
                sel   = ID_W'(i);
            end
        end
    end

    // Output register: precise first, else one held imprecise abort
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abt_valid   <= 1'b0;
            abt_precise <= 1'b0;
            abt_id      <= '0;
            abt_corr    <= 1'b0;
            abt_recov   <= 1'b0;
        end else if (prec_in) begin
            abt_valid   <= 1'b1;
            abt_precise <= 1'b1;
            abt_id      <= prec_id;
            abt_corr    <= prec_corr;
            abt_recov   <= prec_recov;
        end else if (found) begin
            abt_valid   <= 1'b1;
            abt_precise <= 1'b0;
            abt_id      <= sel;
            abt_corr    <= imp_c[sel];
            abt_recov   <= imp_r[sel];
        end else begin
            abt_valid   <= 1'b0;
            abt_precise <= 1'b0;
            abt_id      <= '0;
            abt_corr    <= 1'b0;
            abt_recov   <= 1'b0;
        end
    end

    for (genvar g = 0; g < NID; g++) begin : g_hold
        logic issue_g;
        logic load_g;
        assign issue_g = !prec_in && found && (sel == ID_W'(g));
        assign load_g  = imp_in && (imp_id == ID_W'(g));

        // Ready bit per ID: drop when issued, set on new imprecise commit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                imp_rdy[g] <= 1'b0;
                imp_c[g]   <= 1'b0;
                imp_r[g]   <= 1'b0;
            end else if (load_g) begin
                imp_rdy[g] <= 1'b1;
                imp_c[g]   <= imp_corr;
                imp_r[g]   <= imp_recov;
            end else if (issue_g) begin
                imp_rdy[g] <= 1'b0;
            end
        end
    end

    // A precise abort is never delayed (R11)
    p_prec_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
        prec_in |=> abt_valid && abt_precise && (abt_id == $past(prec_id)));

    // A held imprecise abort leaves as soon as no precise one competes (R11)
    p_imp_drain_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((|imp_rdy) && !prec_in) |=> abt_valid && !abt_precise);
endmodule

// File: rtl/memfault_classifier.sv
// Top of the memory fault classification unit: classifies error reports,
// parks them per access ID until commit or flush, and issues detection
// events, fixes, replays, slave errors and aborts one cycle after commit
// (imprecise aborts one cycle later again).
// Assumes at most one report per access between allocation and commit.
module memfault_classifier
    import mfc_pkg::*;
#(
    parameter int ID_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            det_valid,
    input  logic [ID_W-1:0] det_id,
    input  logic [1:0]      det_src,
    input  logic [1:0]      det_kind,
    input  logic [1:0]      det_mem,
    input  logic [1:0]      det_resp,
    input  logic            det_excl,
    input  logic            det_in_tcm,
    input  logic            det_fixable,
    input  logic            det_retry,
    input  logic            det_from_slave,
    input  logic [1:0]      ecc_policy,
    input  logic            dbg_halt,
    input  logic            cmt_valid,
    input  logic [ID_W-1:0] cmt_id,
    input  logic            fls_valid,
    input  logic [ID_W-1:0] fls_id,
    output logic            evt_det,
    output logic            evt_det_corr,
    output logic            abt_valid,
    output logic            abt_precise,
    output logic [ID_W-1:0] abt_id,
    output logic            abt_corr,
    output logic            abt_recov,
    output logic            replay_valid,
    output logic [ID_W-1:0] replay_id,
    output logic            slverr_valid,
    output logic [ID_W-1:0] slverr_id,
    output logic            fix_valid,
    output logic [ID_W-1:0] fix_id
);
    logic   cls_err;
    fault_t cls_f;
    logic   wr_en;
    logic   hit;
    fault_t hit_f;
    logic   prec_in;
    logic   imp_in;

    mfc_classify u_cls (
        .src        (det_src),
        .kind       (det_kind),
        .mem        (det_mem),
        .resp       (det_resp),
        .excl       (det_excl),
        .in_tcm     (det_in_tcm),
        .fixable    (det_fixable),
        .retry      (det_retry),
        .from_slave (det_from_slave),
        .policy     (ecc_policy),
        .halt       (dbg_halt),
        .err        (cls_err),
        .flt        (cls_f)
    );

    assign wr_en = det_valid && cls_err &&
                   (cls_f.abort || cls_f.slverr || cls_f.replay || cls_f.fix);

    mfc_pend_table #(.ID_W(ID_W)) u_tab (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_id     (det_id),
        .wr_flt    (cls_f),
        .cmt_valid (cmt_valid),
        .cmt_id    (cmt_id),
        .fls_valid (fls_valid),
        .fls_id    (fls_id),
        .hit       (hit),
        .hit_flt   (hit_f)
    );

    assign prec_in = hit && hit_f.abort && hit_f.precise;
    assign imp_in  = hit && hit_f.abort && !hit_f.precise;

    mfc_abort_arb #(.ID_W(ID_W)) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .prec_in     (prec_in),
        .prec_id     (cmt_id),
        .prec_corr   (hit_f.corr),
        .prec_recov  (hit_f.recov),
        .imp_in      (imp_in),
        .imp_id      (cmt_id),
        .imp_corr    (hit_f.corr),
        .imp_recov   (hit_f.recov),
        .abt_valid   (abt_valid),
        .abt_precise (abt_precise),
        .abt_id      (abt_id),
        .abt_corr    (abt_corr),
        .abt_recov   (abt_recov)
    );

    // Detection events, one cycle after the report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_det      <= 1'b0;
            evt_det_corr <= 1'b0;
        end else begin
            evt_det      <= det_valid && cls_err;
            evt_det_corr <= det_valid && cls_err && cls_f.corr;
        end
    end

    // Non-abort commit results, one cycle after the commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            replay_valid <= 1'b0;
            slverr_valid <= 1'b0;
            fix_valid    <= 1'b0;
            replay_id    <= '0;
            slverr_id    <= '0;
            fix_id       <= '0;
        end else begin
            replay_valid <= hit && hit_f.replay;
            slverr_valid <= hit && hit_f.slverr;
            fix_valid    <= hit && hit_f.fix;
            replay_id    <= cmt_id;
            slverr_id    <= cmt_id;
            fix_id       <= cmt_id;
        end
    end

    // Replay and slave error are exclusive outcomes (R10)
    p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({replay_valid, slverr_valid}));

    // Replay never comes with an abort of the same access (R10)
    p_replay_no_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        replay_valid |-> !(abt_valid && abt_precise && (abt_id == replay_id)));
endmodule

// File: tb/sim_memfault_classifier.sv
// Bench: behavioural reference model compared with the outputs on every cycle.
module sim_memfault_classifier;
    localparam int ID_W = 2;
    localparam int NID  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic det_valid = 0, det_excl = 0, det_in_tcm = 0, det_fixable = 0;
    logic det_retry = 0, det_from_slave = 0, dbg_halt = 0;
    logic [ID_W-1:0] det_id = 0, cmt_id = 0, fls_id = 0;
    logic [1:0] det_src = 3, det_kind = 0, det_mem = 0, det_resp = 0, ecc_policy = 0;
    logic cmt_valid = 0, fls_valid = 0;

    logic evt_det, evt_det_corr, abt_valid, abt_precise, abt_corr, abt_recov;
    logic replay_valid, slverr_valid, fix_valid;
    logic [ID_W-1:0] abt_id, replay_id, slverr_id, fix_id;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string cur_req = "R12";

    always #10 clk = ~clk;

    memfault_classifier #(.ID_W(ID_W)) u0 (
        .clk(clk), .rst_n(rst_n), .det_valid(det_valid), .det_id(det_id),
        .det_src(det_src), .det_kind(det_kind), .det_mem(det_mem),
        .det_resp(det_resp), .det_excl(det_excl), .det_in_tcm(det_in_tcm),
        .det_fixable(det_fixable), .det_retry(det_retry),
        .det_from_slave(det_from_slave), .ecc_policy(ecc_policy),
        .dbg_halt(dbg_halt), .cmt_valid(cmt_valid), .cmt_id(cmt_id),
        .fls_valid(fls_valid), .fls_id(fls_id), .evt_det(evt_det),
        .evt_det_corr(evt_det_corr), .abt_valid(abt_valid),
        .abt_precise(abt_precise), .abt_id(abt_id), .abt_corr(abt_corr),
        .abt_recov(abt_recov), .replay_valid(replay_valid),
        .replay_id(replay_id), .slverr_valid(slverr_valid),
        .slverr_id(slverr_id), .fix_valid(fix_valid), .fix_id(fix_id)
    );

    // Reference classification: {err, abort, precise, slverr, replay, fix, corr, recov}
    function automatic logic [7:0] ref_cls(input logic [1:0] s, k, m, r, p,
                                           input logic ex, tc, fx, rt, sl, hl);
        logic e, ab, pr, sv, rp, fi, co, rc;
        {e, ab, pr, sv, rp, fi, co, rc} = '0;
        if (s == 0) begin
            if (r >= 2 || (ex && k == 1 && r == 0)) begin
                e = 1; ab = 1;
                pr = (k <= 1) || (k == 2 && m == 2);
            end
        end else if (s == 1) begin
            e = 1;
            if (sl) sv = 1;
            else if (k != 2 && rt) begin rp = 1; rc = 1; end
            else begin ab = 1; pr = (k != 2); end
        end else if (s == 2) begin
            e = 1; co = fx; rc = fx;
            if (p == 1) ab = 1;
            if (p == 2) begin fi = fx; ab = !fx || hl; end
            if (p == 3) begin fi = fx; ab = 1; end
            pr = (k == 3) ? 1'b0 : ((k == 2) ? tc : 1'b1);
        end
        return {e, ab, pr, sv, rp, fi, co, rc};
    endfunction

    // Model state and expected outputs
    logic [NID-1:0] mv = '0, mi = '0, mic = '0, mir = '0;
    logic [7:0] mf [NID];
    logic x_det = 0, x_detc = 0, x_abt = 0, x_ap = 0, x_ac = 0, x_ar = 0;
    logic x_rep = 0, x_slv = 0, x_fix = 0;
    int x_aid = 0, x_cid = 0;

    always @(posedge clk) begin
        logic [7:0] c, hf;
        logic hit, pr, im, found;
        if (!rst_n) begin
            mv = '0; mi = '0; mic = '0; mir = '0;
            {x_det, x_detc, x_abt, x_ap, x_ac, x_ar, x_rep, x_slv, x_fix} = '0;
        end else begin
            c = ref_cls(det_src, det_kind, det_mem, det_resp, ecc_policy, det_excl,
                        det_in_tcm, det_fixable, det_retry, det_from_slave, dbg_halt);
            x_det  = det_valid && c[7];
            x_detc = det_valid && c[7] && c[1];
            hit = cmt_valid && mv[cmt_id] && !(fls_valid && fls_id == cmt_id);
            hf  = mf[cmt_id];
            x_rep = hit && hf[3];
            x_slv = hit && hf[4];
            x_fix = hit && hf[2];
            x_cid = cmt_id;
            pr = hit && hf[6] && hf[5];
            im = hit && hf[6] && !hf[5];
            x_abt = 0;
            if (pr) begin
                x_abt = 1; x_ap = 1; x_aid = cmt_id; x_ac = hf[1]; x_ar = hf[0];
            end else begin
                found = 0;
                for (int i = 0; i < NID; i++) begin
                    if (!found && mi[i]) begin
                        found = 1; x_abt = 1; x_ap = 0; x_aid = i;
                        x_ac = mic[i]; x_ar = mir[i]; mi[i] = 0;
                    end
                end
            end
            if (im) begin mi[cmt_id] = 1; mic[cmt_id] = hf[1]; mir[cmt_id] = hf[0]; end
            if (cmt_valid) mv[cmt_id] = 0;
            if (fls_valid) mv[fls_id] = 0;
            if (det_valid && c[7] && (|c[6:2]) && !(cmt_valid && cmt_id == det_id) &&
                !(fls_valid && fls_id == det_id)) begin
                mv[det_id] = 1; mf[det_id] = c;
            end
        end
    end

    task automatic chk(input string nm, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", cur_req, nm, act, exp, $time);
        end
    endtask

    // Compare every output with the model away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            chk("evt_det", evt_det, x_det);
            chk("evt_det_corr", evt_det_corr, x_detc);
            chk("abt_valid", abt_valid, x_abt);
            if (x_abt) begin
                chk("abt_precise", abt_precise, x_ap);
                chk("abt_id", abt_id, x_aid);
                chk("abt_corr", abt_corr, x_ac);
                chk("abt_recov", abt_recov, x_ar);
            end
            chk("replay_valid", replay_valid, x_rep);
            chk("slverr_valid", slverr_valid, x_slv);
            chk("fix_valid", fix_valid, x_fix);
            if (x_rep) chk("replay_id", replay_id, x_cid);
            if (x_slv) chk("slverr_id", slverr_id, x_cid);
            if (x_fix) chk("fix_id", fix_id, x_cid);
        end
    end

    task automatic det(input int id, s, k, m, r, input bit ex = 0, tc = 0,
                       fx = 0, rt = 0, sl = 0);
        det_valid = 1; det_id = ID_W'(id); det_src = 2'(s); det_kind = 2'(k);
        det_mem = 2'(m); det_resp = 2'(r); det_excl = ex; det_in_tcm = tc;
        det_fixable = fx; det_retry = rt; det_from_slave = sl;
        @(negedge clk);
        det_valid = 0; det_src = 3;
    endtask

    task automatic cmt(input int id);
        cmt_valid = 1; cmt_id = ID_W'(id);
        @(negedge clk);
        cmt_valid = 0;
    endtask

    task automatic fls(input int id);
        fls_valid = 1; fls_id = ID_W'(id);
        @(negedge clk);
        fls_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        idle(2);
        // R1: bus errors, precise and imprecise, and non-errors
        cur_req = "R1";
        det(0, 0, 1, 0, 2); cmt(0); idle(2);
        det(1, 0, 2, 0, 3); cmt(1); idle(3);
        det(2, 0, 2, 2, 2); cmt(2); idle(2);
        det(3, 0, 2, 1, 2); cmt(3); idle(3);
        det(0, 0, 3, 0, 3); cmt(0); idle(3);
        det(1, 0, 0, 0, 3); cmt(1); idle(2);
        det(2, 0, 1, 0, 0); cmt(2); idle(2);
        det(2, 0, 1, 0, 1); cmt(2); idle(2);
        // R2: exclusive OKAY reclassified, exclusive EXOKAY clean
        cur_req = "R2";
        det(0, 0, 1, 0, 0, 1); cmt(0); idle(2);
        det(1, 0, 1, 0, 1, 1); cmt(1); idle(2);
        // R3: RAM error precision under abort policy
        cur_req = "R3";
        ecc_policy = 1;
        det(0, 2, 1, 0, 0); cmt(0); idle(2);
        det(1, 2, 2, 0, 0, 0, 1); cmt(1); idle(2);
        det(2, 2, 2, 0, 0, 0, 0); cmt(2); idle(3);
        det(3, 2, 3, 0, 0, 0, 1); cmt(3); idle(3);
        det(0, 2, 0, 0, 0, 0, 0, 1); cmt(0); idle(2);
        // R4: the four policies, fixable and not
        cur_req = "R4";
        for (int p = 0; p < 4; p++) begin
            ecc_policy = 2'(p);
            det(p, 2, 1, 0, 0, 0, 0, 1); cmt(p); idle(2);
            det(p, 2, 2, 0, 0, 0, 0, 0); cmt(p); idle(3);
        end
        // R5: debug halt forces abort on silent fix
        cur_req = "R5";
        ecc_policy = 2; dbg_halt = 1;
        det(1, 2, 1, 0, 0, 0, 0, 1); cmt(1); idle(2);
        det(2, 2, 2, 0, 0, 0, 0, 1); cmt(2); idle(3);
        dbg_halt = 0;
        det(3, 2, 1, 0, 0, 0, 0, 1); cmt(3); idle(2);
        // R6: events with no abort, under ignore policy
        cur_req = "R6";
        ecc_policy = 0;
        det(0, 2, 1, 0, 0, 0, 0, 1); idle(1); det(1, 2, 1, 0, 0, 0, 0, 0);
        cmt(0); cmt(1); idle(2);
        // R7: flush drops the error, commit without error does nothing
        cur_req = "R7";
        ecc_policy = 1;
        det(3, 0, 1, 0, 2); fls(3); cmt(3); idle(2);
        cmt(2); idle(2);
        det(2, 0, 1, 0, 2); idle(2); cmt(2); cmt(2); idle(2);
        // R8: correctable/recoverable flags on aborts
        cur_req = "R8";
        ecc_policy = 3;
        det(0, 2, 1, 0, 0, 0, 0, 1); cmt(0); idle(2);
        det(1, 2, 1, 0, 0, 0, 0, 0); cmt(1); idle(2);
        det(2, 0, 0, 0, 2); cmt(2); idle(2);
        // R9: TCM port read, write, slave-origin
        cur_req = "R9";
        det(0, 1, 1, 0, 0); cmt(0); idle(2);
        det(1, 1, 2, 0, 0); cmt(1); idle(3);
        det(2, 1, 1, 0, 0, 0, 0, 0, 0, 1); cmt(2); idle(2);
        det(3, 1, 2, 0, 0, 0, 0, 0, 1, 1); cmt(3); idle(2);
        // R10: retry on read replays, retry on write aborts
        cur_req = "R10";
        det(0, 1, 1, 0, 0, 0, 0, 0, 1); cmt(0); idle(2);
        det(1, 1, 0, 0, 0, 0, 0, 0, 1); cmt(1); idle(2);
        det(2, 1, 2, 0, 0, 0, 0, 0, 1); cmt(2); idle(3);
        // R11: held imprecise abort loses to a precise one
        cur_req = "R11";
        det(1, 0, 2, 0, 2); det(2, 0, 1, 0, 2); det(3, 0, 0, 0, 3); det(0, 0, 2, 1, 3);
        cmt(1); cmt(2); cmt(3); cmt(0); idle(4);
        det(3, 2, 3, 0, 0, 0, 0, 1); det(0, 2, 1, 0, 0, 0, 0, 1);
        cmt(3); cmt(0); idle(4);
        // R12: reset mid-flight clears pending state
        cur_req = "R12";
        det(1, 0, 1, 0, 2);
        rst_n = 0; idle(2); rst_n = 1; idle(1);
        cmt(1); idle(3);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule